// File: doc/BRIEF.md
# Segment translation and protection unit

This block turns a logical address, given as a segment number and an offset, into a physical address. The segment descriptors sit in ordinary memory. A table-origin input gives the byte address of descriptor zero, and a table-size input gives how many descriptors are present. For each request the unit reads the selected descriptor over a simple read port. It checks that the segment exists, that it is marked usable, that the offset falls inside it and that the access kind is allowed. It then answers with either a relocated address or a fault code.

Each descriptor is two 32-bit words, eight bytes in all. The first word is the segment base. The second word carries a usable flag in bit 31, a read permission in bit 30, a write permission in bit 29, an execute permission in bit 28, and the segment length in its low OFF_W bits. The unit takes one request at a time and gives exactly one response per request. Both sides use a valid/ready handshake.

Top module: `seg_xlate_unit`

## Requirements
- R1: While reset is asserted, and right after it is released, req_ready is 1, rsp_valid is 0 and mem_req_valid is 0.
- R2: A request is taken when req_valid and req_ready are both 1. From then on, req_ready stays 0 until the response is taken with rsp_valid and rsp_ready. While rsp_valid is 1 and rsp_ready is 0, rsp_paddr and rsp_fault hold their values.
- R3: If the segment number is not below the table size, the response carries fault code 1 and no memory read is issued.
- R4: A legal segment s causes exactly two reads, in this order: address origin + 8*s, then origin + 8*s + 4. mem_addr holds steady while mem_req_valid is 1 and mem_req_ready is 0.
- R5: If bit 31 of word 1 is 0, the response carries fault code 2. This takes priority over the limit and permission checks.
- R6: If the offset is greater than or equal to the length field (word 1 bits OFF_W-1:0), the response carries fault code 3. This takes priority over the permission check. Only the codes 0 to 4 ever appear.
- R7: The access code selects the permission bit that must be 1: code 0 (read) uses bit 30, code 1 (write) uses bit 29 and code 2 (execute) uses bit 28. Code 3 always faults. A failed permission check gives fault code 4.
- R8: When every check passes, the fault code is 0 and rsp_paddr equals word 0 plus the zero-extended offset, modulo 2^ADDR_W.
- R9: Whenever the fault code is not 0, rsp_paddr is 0.
- R10: The table origin and table size are sampled in the cycle the request is taken. Changing them afterwards has no effect on that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_base | input | ADDR_W | Byte address of descriptor 0 |
| tbl_len | input | SEG_W+1 | Number of descriptors in the table |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within the segment |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| mem_req_valid | output | 1 | Descriptor word read request |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_addr | output | ADDR_W | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Read data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | ADDR_W | Physical address, or 0 on a fault |
| rsp_fault | output | 3 | Fault code, 0 when none |

## Verification
The hardest case to reach from the ports is a request whose table registers change while its descriptor fetch is stalled. A second hard case is a descriptor that breaks several rules at once, so that only the priority order decides the code. The bench makes the memory model's ready signal stall on a cycle pattern. During such a stall it rewrites the table origin and table size, then checks that both read addresses and the result still follow the values from the moment the request was taken. Descriptors are built to fail the usable flag together with the limit, and the limit together with the permission, which exercises each priority boundary.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD0_REQ  = 3'd1,
        ST_RD0_WAIT = 3'd2,
        ST_RD1_REQ  = 3'd3,
        ST_RD1_WAIT = 3'd4,
        ST_RESP     = 3'd5
    } xl_state_e;

    localparam logic [2:0] FLT_NONE    = 3'd0;
    localparam logic [2:0] FLT_RANGE   = 3'd1;
    localparam logic [2:0] FLT_UNUSED  = 3'd2;
    localparam logic [2:0] FLT_LIMIT   = 3'd3;
    localparam logic [2:0] FLT_PERM    = 3'd4;

    localparam logic [1:0] ACC_READ  = 2'd0;
    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_EXEC  = 2'd2;

    localparam int unsigned USE_BIT   = 31;
    localparam int unsigned RD_BIT    = 30;
    localparam int unsigned WR_BIT    = 29;
    localparam int unsigned EX_BIT    = 28;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned DESC_SHIFT = 3;
    localparam int unsigned WORD_BYTES = 4;

endpackage

// File: rtl/seg_bound_check.sv
module seg_bound_check #(
    parameter int unsigned SEG_W = 8
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [SEG_W:0]   count,
    output logic             in_range
);
    always_comb begin
        in_range = ({1'b0, seg} < count);
    end
endmodule

// File: rtl/seg_entry_check.sv
module seg_entry_check
    import seg_xlate_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 28
) (
    input  logic [WORD_W-1:0] word0,
    input  logic [WORD_W-1:0] word1,
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        acc,
    output logic [2:0]        fault,
    output logic [ADDR_W-1:0] paddr
);
    logic [OFF_W-1:0] seg_len;
    logic             perm_ok;

    always_comb begin
        seg_len = word1[OFF_W-1:0];
        case (acc)
            ACC_READ:  perm_ok = word1[RD_BIT];
            ACC_WRITE: perm_ok = word1[WR_BIT];
            ACC_EXEC:  perm_ok = word1[EX_BIT];
            default:   perm_ok = 1'b0;
        endcase

        if (!word1[USE_BIT]) begin
            fault = FLT_UNUSED;
        end else if (off >= seg_len) begin
            fault = FLT_LIMIT;
        end else if (!perm_ok) begin
            fault = FLT_PERM;
        end else begin
            fault = FLT_NONE;
        end

        if (fault == FLT_NONE) begin
            paddr = ADDR_W'(word0) + ADDR_W'(off);
        end else begin
            paddr = '0;
        end
    end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter int unsigned SEG_W  = 8,
    parameter int unsigned OFF_W  = 28,
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [SEG_W:0]    tbl_len,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_acc,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [2:0]        rsp_fault
);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(WORD_BYTES);

    typedef struct packed {
        xl_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic [OFF_W-1:0]  off;
        logic [1:0]        acc;
        logic [WORD_W-1:0] w0;
        logic [ADDR_W-1:0] paddr;
        logic [2:0]        fault;
    } regs_t;

    regs_t d, q;

    logic              seg_in_range;
    logic [2:0]        chk_fault;
    logic [ADDR_W-1:0] chk_paddr;
    logic [ADDR_W-1:0] desc_ofs;

    seg_bound_check #(.SEG_W(SEG_W)) u_bound (
        .seg      (req_seg),
        .count    (tbl_len),
        .in_range (seg_in_range)
    );

    seg_entry_check #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_entry (
        .word0 (q.w0),
        .word1 (mem_rsp_data),
        .off   (q.off),
        .acc   (q.acc),
        .fault (chk_fault),
        .paddr (chk_paddr)
    );

    always_comb begin
        d             = q;
        desc_ofs      = ADDR_W'(req_seg) << DESC_SHIFT;
        req_ready     = (q.st == ST_IDLE);
        rsp_valid     = (q.st == ST_RESP);
        rsp_paddr     = q.paddr;
        rsp_fault     = q.fault;
        mem_req_valid = 1'b0;
        mem_addr      = q.addr;

        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.off  = req_off;
                    d.acc  = req_acc;
                    d.addr = tbl_base + desc_ofs;
                    if (!seg_in_range) begin
                        d.fault = FLT_RANGE;
                        d.paddr = '0;
                        d.st    = ST_RESP;
                    end else begin
                        d.st = ST_RD0_REQ;
                    end
                end
            end
            ST_RD0_REQ: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) d.st = ST_RD0_WAIT;
            end
            ST_RD0_WAIT: begin
                if (mem_rsp_valid) begin
                    d.w0   = mem_rsp_data;
                    d.addr = q.addr + WORD_STEP;
                    d.st   = ST_RD1_REQ;
                end
            end
            ST_RD1_REQ: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) d.st = ST_RD1_WAIT;
            end
            ST_RD1_WAIT: begin
                if (mem_rsp_valid) begin
                    d.fault = chk_fault;
                    d.paddr = chk_paddr;
                    d.st    = ST_RESP;
                end
            end
            ST_RESP: begin
                if (rsp_ready) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)); // R2
    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || mem_req_valid) |-> !req_ready); // R2
    AST_RANGE_SKIPS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !seg_in_range |=> rsp_valid && !mem_req_valid && rsp_fault == 3'd1); // R3
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr)); // R4
    AST_FAULT_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_fault <= 3'd4); // R6
    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault != 3'd0 |-> rsp_paddr == '0); // R9

endmodule

// File: tb/seg_xlate_unit_test.sv
module seg_xlate_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int SEG_W  = 8;
    localparam int OFF_W  = 28;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] tbl_base;
    logic [SEG_W:0]    tbl_len;
    logic              req_valid;
    logic              req_ready;
    logic [SEG_W-1:0]  req_seg;
    logic [OFF_W-1:0]  req_off;
    logic [1:0]        req_acc;
    logic              mem_req_valid;
    logic              mem_req_ready;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [31:0]       mem_rsp_data = '0;
    logic              rsp_valid;
    logic              rsp_ready;
    logic [ADDR_W-1:0] rsp_paddr;
    logic [2:0]        rsp_fault;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] mem_arr [0:255];
    logic        stall_en = 1'b0;
    logic [1:0]  stall_q = 2'd0;
    int          rd_total = 0;
    logic [31:0] last_addr = '0;
    logic [31:0] prev_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_xlate_unit #(.SEG_W(SEG_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base), .tbl_len(tbl_len),
        .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg),
        .req_off(req_off), .req_acc(req_acc),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    // memory model: optional stall pattern, one-cycle read latency
    assign mem_req_ready = stall_en ? (stall_q == 2'd3) : 1'b1;

    always @(posedge clk) begin
        stall_q       <= stall_q + 2'd1;
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem_arr[mem_addr[9:2]];
            prev_addr     <= last_addr;
            last_addr     <= mem_addr;
            rd_total      <= rd_total + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_w1(input bit u, input bit r, input bit w,
                                          input bit x, input logic [27:0] len);
        return {u, r, w, x, len};
    endfunction

    // one request; hold = cycles the response is left pending; chg = rewrite table regs after accept
    task automatic run_req(input string tag, input logic [7:0] seg, input logic [27:0] off,
                           input logic [1:0] acc, input int hold, input bit chg,
                           input logic [2:0] exp_fault, input logic [31:0] exp_paddr,
                           input int exp_reads, input logic [31:0] exp_a0);
        int r0;
        int n;
        logic [31:0] p;
        logic [2:0]  f;
        logic [31:0] keep_base;
        logic [8:0]  keep_len;
        r0 = rd_total;
        keep_base = tbl_base;
        keep_len  = tbl_len;
        @(negedge clk);
        chk({tag, " R2 idle ready"}, 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_seg = seg; req_off = off; req_acc = acc;
        @(negedge clk);
        req_valid = 1'b0;
        if (chg) begin
            tbl_base = 32'h0000_0200;
            tbl_len  = 9'd0;
        end
        n = 0;
        while (!rsp_valid && n < 60) begin
            chk({tag, " R2 busy"}, 32'(req_ready), 32'd0);
            @(negedge clk);
            n++;
        end
        chk({tag, " R2 response arrives"}, 32'(rsp_valid), 32'd1);
        p = rsp_paddr;
        f = rsp_fault;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk({tag, " R2 hold valid"}, 32'(rsp_valid), 32'd1);
            chk({tag, " R2 hold paddr"}, rsp_paddr, p);
            chk({tag, " R2 hold fault"}, 32'(rsp_fault), 32'(f));
            chk({tag, " R2 no accept"}, 32'(req_ready), 32'd0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk({tag, " R2 released"}, {30'd0, rsp_valid, req_ready}, 32'd1);
        chk({tag, " fault"}, 32'(f), 32'(exp_fault));
        chk({tag, " paddr"}, p, exp_paddr);
        chk({tag, " read count"}, 32'(rd_total - r0), 32'(exp_reads));
        if (exp_reads == 2) begin
            chk({tag, " R4 word0 addr"}, prev_addr, exp_a0);
            chk({tag, " R4 word1 addr"}, last_addr, exp_a0 + 32'd4);
        end
        if (chg) begin
            tbl_base = keep_base;
            tbl_len  = keep_len;
        end
    endtask

    task automatic t_reset;
        chk("R1 req_ready in reset", 32'(req_ready), 32'd1);
        chk("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        chk("R1 mem_req_valid in reset", 32'(mem_req_valid), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req_ready after reset", 32'(req_ready), 32'd1);
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk("R1 mem_req_valid after reset", 32'(mem_req_valid), 32'd0);
    endtask

    task automatic t_success;
        run_req("R8 s0 read", 8'd0, 28'h10, 2'd0, 0, 1'b0, 3'd0, 32'h0001_0010, 2, 32'h100);
        run_req("R8 s0 write at limit-1", 8'd0, 28'hFF, 2'd1, 0, 1'b0, 3'd0, 32'h0001_00FF, 2, 32'h100);
        run_req("R7 s2 execute", 8'd2, 28'h3F, 2'd2, 0, 1'b0, 3'd0, 32'h2000_003F, 2, 32'h110);
        run_req("R8 s3 wrap", 8'd3, 28'h1F, 2'd0, 0, 1'b0, 3'd0, 32'h0000_000F, 2, 32'h118);
    endtask

    task automatic t_faults;
        run_req("R6 s0 offset at limit", 8'd0, 28'h100, 2'd0, 0, 1'b0, 3'd3, 32'h0, 2, 32'h100);
        run_req("R7 s0 execute denied", 8'd0, 28'h4, 2'd2, 0, 1'b0, 3'd4, 32'h0, 2, 32'h100);
        run_req("R7 code3 denied", 8'd0, 28'h4, 2'd3, 0, 1'b0, 3'd4, 32'h0, 2, 32'h100);
        run_req("R5 unused beats limit", 8'd1, 28'h20, 2'd0, 0, 1'b0, 3'd2, 32'h0, 2, 32'h108);
        run_req("R6 limit beats perm", 8'd2, 28'h50, 2'd0, 0, 1'b0, 3'd3, 32'h0, 2, 32'h110);
        run_req("R9 s3 write denied", 8'd3, 28'h1, 2'd1, 0, 1'b0, 3'd4, 32'h0, 2, 32'h118);
    endtask

    task automatic t_range;
        run_req("R3 seg equal size", 8'd4, 28'h0, 2'd0, 0, 1'b0, 3'd1, 32'h0, 0, 32'h0);
        run_req("R3 seg far out", 8'd200, 28'h0, 2'd0, 0, 1'b0, 3'd1, 32'h0, 0, 32'h0);
        tbl_len = 9'd0;
        run_req("R3 empty table", 8'd0, 28'h10, 2'd0, 0, 1'b0, 3'd1, 32'h0, 0, 32'h0);
        tbl_len = 9'd4;
    endtask

    task automatic t_stall;
        stall_en = 1'b1;
        run_req("R2 R4 stalled hold", 8'd0, 28'h20, 2'd1, 3, 1'b0, 3'd0, 32'h0001_0020, 2, 32'h100);
        run_req("R10 regs change mid fetch", 8'd2, 28'h1, 2'd2, 1, 1'b1, 3'd0, 32'h2000_0001, 2, 32'h110);
        stall_en = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem_arr[i] = 32'hDEAD_0000 | 32'(i);
        // table at 0x100 -> word index 0x40
        mem_arr[8'h40] = 32'h0001_0000; mem_arr[8'h41] = mk_w1(1, 1, 1, 0, 28'h100);
        mem_arr[8'h42] = 32'h0005_0000; mem_arr[8'h43] = mk_w1(0, 1, 1, 1, 28'h10);
        mem_arr[8'h44] = 32'h2000_0000; mem_arr[8'h45] = mk_w1(1, 0, 0, 1, 28'h40);
        mem_arr[8'h46] = 32'hFFFF_FFF0; mem_arr[8'h47] = mk_w1(1, 1, 0, 0, 28'h20);
        // decoy table at 0x200 -> word index 0x80, all entries unusable
        for (int i = 8'h80; i < 8'h90; i++) mem_arr[i] = 32'h0;
        rst_n = 1'b0; req_valid = 1'b0; rsp_ready = 1'b0;
        req_seg = '0; req_off = '0; req_acc = '0;
        tbl_base = 32'h0000_0100; tbl_len = 9'd4;
        repeat (3) @(negedge clk);
        t_reset();
        t_success();
        t_faults();
        t_range();
        t_stall();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule